// File: doc/BRIEF.md
# Streaming QRS Complex Detector

This block finds heartbeats in a single stream of signed ECG samples that arrive at 360 Hz. The clock runs much faster than the sample rate, so `in_valid` strobes once per sample. On each strobe the sample goes through a fixed chain of stages. A 1-2-1 smoothing filter comes first, then a first difference and a saturating square. A moving-window sum over the last eleven squared values follows, with its result scaled down to give the integrated energy. The last stage compares that energy with an adaptive threshold.

The threshold follows the signal. It is built from two exponential averages, each with a weight of 1/8: one tracks the energy itself and one tracks the mean absolute deviation of the energy from that average. A beat is declared at a local maximum of the energy that lies above the threshold. The block then emits a one-cycle pulse and reports the sample number of the peak. No beat is reported while the statistics are still training after reset, or during a refractory window that follows each beat.

Top module: `qrs_detector`

## Requirements
- R1: While reset is asserted and until the first strobe after it, `beat` is 0, `energy` is 0 and `peak_idx` is 0.
- R2: Number the accepted samples from n = 0, with x[n] = 0 for n < 0. Each strobe computes the following:
  - f[n] = (x[n] + 2x[n-1] + x[n-2]) >>> 2 (arithmetic shift)
  - d[n] = f[n] - f[n-1]
  - s[n] = d[n]^2
  - e[n] = (s[n] + s[n-1] + ... + s[n-10]) >> 3

  `energy` shows e[n] from the clock edge that accepts x[n].
- R3: A squared value s[n] above 65535 is clamped to 65535 before it enters the window sum. It never wraps.
- R4: No beat is reported for samples n < 720, the first 2 s of samples.
- R5: The statistics are mean m and deviation v, both starting at 0. After each sample they update as follows, with both right-hand sides using the old m:
  - m += (e[n] - m) >>> 3
  - v += (|e[n] - m| - v) >>> 3

  A beat is declared at sample n when e[n-1] > m + (v >> 1) and e[n] < e[n-1]. Here m and v are their values after sample n-1, and e[-1] = 0.
- R6: A beat at sample n blocks any beat at samples n+1 through n+72.
- R7: On a beat at sample n, `peak_idx` becomes (n-1) mod 2^16, the index of the peak sample. Between beats it holds its value.
- R8: `beat` is high for exactly the one cycle after the accepting edge. Neither `beat` nor `energy` changes on cycles without a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe, one cycle per sample |
| in_sample | input | 12 | Signed ECG sample |
| beat | output | 1 | One-cycle beat pulse |
| peak_idx | output | 16 | Sample index of the last detected peak |
| energy | output | 17 | Integrated energy of the newest sample |

## Verification
The hardest condition to reach from the ports is a second genuine energy peak that falls inside the refractory window of a beat that has already been accepted. That peak must occur after training has finished and must rise above a threshold that has adapted to the earlier beats. The stimulus first runs 1440 samples of regular spikes on low-level noise so that the statistics settle. It then places two spikes 40 samples apart and counts the candidates the window suppresses. A closing burst of full-scale steps drives the square into its clamp.

// File: rtl/qrs_detector.sv
module qrs_detector #(
  parameter int DW      = 12,
  parameter int EW      = 16,
  parameter int WIN     = 11,
  parameter int ISH     = 3,
  parameter int TRAIN   = 720,
  parameter int REFRACT = 72,
  parameter int IW      = 16,
  localparam int OW     = EW + $clog2(WIN) - ISH
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [DW-1:0] in_sample,
  output logic                 beat,
  output logic [IW-1:0]        peak_idx,
  output logic [OW-1:0]        energy
);
  localparam int SW = EW + $clog2(WIN);
  localparam int PW = 2 * (DW + 1);
  localparam int AW = $clog2(WIN);
  localparam int CW = $clog2(TRAIN + 1);
  localparam int RW = $clog2(REFRACT + 1);

  logic signed [DW-1:0] x1, x2, lp1, lp;
  logic signed [DW+1:0] fir;
  logic signed [DW:0]   d;
  logic signed [PW-1:0] prod;
  logic [EW-1:0]        sq;
  logic [EW-1:0]        win_q [WIN];
  logic [AW-1:0]        ptr;
  logic [SW-1:0]        sum, sum_n;
  logic [OW-1:0]        e_n, e_q, mean, dev, mean_n, dev_n, absd;
  logic signed [OW:0]   diff, spread;
  logic [OW:0]          thr;
  logic [CW-1:0]        seen;
  logic [RW-1:0]        refr;
  logic [IW-1:0]        idx;
  logic                 hit;

  assign fir    = (DW+2)'(in_sample) + ((DW+2)'(x1) <<< 1) + (DW+2)'(x2);
  assign lp     = DW'(fir >>> 2);
  assign d      = (DW+1)'(lp) - (DW+1)'(lp1);
  assign prod   = PW'(d) * PW'(d);
  assign sq     = (|prod[PW-1:EW]) ? '1 : prod[EW-1:0];
  assign sum_n  = sum + SW'(sq) - SW'(win_q[ptr]);
  assign e_n    = OW'(sum_n >> ISH);

  assign diff   = $signed({1'b0, e_n}) - $signed({1'b0, mean});
  assign mean_n = OW'($signed({1'b0, mean}) + (diff >>> 3));
  assign absd   = OW'(diff[OW] ? -diff : diff);
  assign spread = $signed({1'b0, absd}) - $signed({1'b0, dev});
  assign dev_n  = OW'($signed({1'b0, dev}) + (spread >>> 3));
  assign thr    = {1'b0, mean} + (OW+1)'(dev >> 1);

  assign hit    = (seen == CW'(TRAIN)) && (refr == '0) &&
                  ({1'b0, e_q} > thr) && (e_n < e_q);
  assign energy = e_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x1 <= '0; x2 <= '0; lp1 <= '0;
      for (int i = 0; i < WIN; i++) win_q[i] <= '0;
      ptr <= '0; sum <= '0; e_q <= '0; mean <= '0; dev <= '0;
      seen <= '0; refr <= '0; idx <= '0;
      beat <= 1'b0; peak_idx <= '0;
    end else begin
      beat <= 1'b0;
      if (in_valid) begin
        x2 <= x1;
        x1 <= in_sample;
        lp1 <= lp;
        win_q[ptr] <= sq;
        ptr <= (ptr == AW'(WIN - 1)) ? '0 : ptr + 1'b1;
        sum <= sum_n;
        e_q <= e_n;
        mean <= mean_n;
        dev <= dev_n;
        idx <= idx + 1'b1;
        if (seen != CW'(TRAIN)) seen <= seen + 1'b1;
        beat <= hit;
        if (hit) begin
          refr <= RW'(REFRACT);
          peak_idx <= idx - 1'b1;
        end else if (refr != '0) begin
          refr <= refr - 1'b1;
        end
      end
    end
  end

  // R8
  beat_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat |=> !beat);

  // R8
  energy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(in_valid) |-> $stable(energy));

  // R4
  train_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> $past(seen) == CW'(TRAIN));

  // R6
  refract_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    beat |-> $past(refr) == '0);

  // R7
  peak_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !beat |-> $stable(peak_idx));
endmodule

// File: tb/tb_qrs_detector.sv
`timescale 1ns/1ps
module tb_qrs_detector;
  localparam int DW = 12, WIN = 11, ISH = 3, TRAIN = 720, REFRACT = 72;
  localparam int IW = 16, OW = 17;

  logic clk = 1'b0;
  logic rst_n, in_valid;
  logic signed [DW-1:0] in_sample;
  logic beat;
  logic [IW-1:0] peak_idx;
  logic [OW-1:0] energy;

  always #2.5 clk = ~clk;

  qrs_detector dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sample(in_sample),
    .beat(beat), .peak_idx(peak_idx), .energy(energy)
  );

  int checks = 0, fails = 0;
  bit done = 1'b0;

  int mx1, mx2, mlp1, mptr, msum, mmean, mdev, meprev, mrefr, mn, satage;
  int mbuf [WIN];
  int nbeats = 0, nsupp = 0, ntrain_cand = 0, nsat = 0;
  bit [31:0] lcg = 32'h1234_5678;

  task automatic chk(bit ok, string tag, longint act, longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic send(int x, int gap);
    int lp, d, sq, e, diff, ad;
    longint p;
    bit cand, b;
    lp = (x + 2 * mx1 + mx2) >>> 2;
    d  = lp - mlp1;
    p  = longint'(d) * d;
    if (p > 65535) begin sq = 65535; satage = 0; nsat++; end
    else begin sq = int'(p); satage++; end
    msum = msum + sq - mbuf[mptr];
    mbuf[mptr] = sq;
    mptr = (mptr == WIN - 1) ? 0 : mptr + 1;
    e = msum >>> ISH;
    cand = (meprev > mmean + (mdev >>> 1)) && (e < meprev);
    b = cand && (mn >= TRAIN) && (mrefr == 0);
    if (cand && mn < TRAIN) ntrain_cand++;
    if (cand && mn >= TRAIN && mrefr != 0) nsupp++;
    if (b) nbeats++;
    diff = e - mmean;
    ad = diff < 0 ? -diff : diff;
    mdev = mdev + ((ad - mdev) >>> 3);
    mmean = mmean + (diff >>> 3);
    if (b) mrefr = REFRACT; else if (mrefr != 0) mrefr--;
    meprev = e;
    mx2 = mx1; mx1 = x; mlp1 = lp;

    in_valid = 1'b1;
    in_sample = DW'(x);
    @(negedge clk);
    in_valid = 1'b0;
    chk(energy == OW'(e), (satage < WIN) ? "R3 energy" : "R2 energy", energy, e);
    if (b)
      chk(beat == 1'b1, "R5 beat", beat, 1);
    else if (mn < TRAIN)
      chk(beat == 1'b0, "R4 beat", beat, 0);
    else if (cand)
      chk(beat == 1'b0, "R6 beat", beat, 0);
    else
      chk(beat == 1'b0, "R5 beat", beat, 0);
    if (b) chk(peak_idx == IW'(mn - 1), "R7 peak_idx", peak_idx, (mn - 1) & 16'hFFFF);
    mn++;
    repeat (gap) begin
      @(negedge clk);
      chk(beat == 1'b0 && energy == OW'(e), "R8 idle", {beat, energy}, e);
    end
  endtask

  function automatic int tri_pulse(int k);
    return (k >= 0 && k < 7) ? 600 - 200 * ((k > 3) ? k - 3 : 3 - k) : 0;
  endfunction

  function automatic int stim(int n, int noise);
    if (n < 1440) return tri_pulse(n % 180) + noise;
    if (n < 1800) return tri_pulse(n - 1460) + tri_pulse(n - 1500) + tri_pulse(n - 1620) + noise;
    return (((n / 2) % 2) != 0) ? -2000 : 2000;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int noise;
    mx1 = 0; mx2 = 0; mlp1 = 0; mptr = 0; msum = 0; mmean = 0; mdev = 0;
    meprev = 0; mrefr = 0; mn = 0; satage = WIN;
    for (int i = 0; i < WIN; i++) mbuf[i] = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_sample = '0;
    repeat (3) @(negedge clk);
    chk(beat == 1'b0 && energy == '0 && peak_idx == '0, "R1 in reset", {beat, energy, peak_idx}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(beat == 1'b0 && energy == '0 && peak_idx == '0, "R1 after reset", {beat, energy, peak_idx}, 0);
    for (int n = 0; n < 1900; n++) begin
      lcg = lcg * 32'd1103515245 + 32'd12345;
      noise = int'((lcg >> 16) & 32'd15) - 8;
      send(stim(n, noise), n % 4);
    end
    chk(nbeats >= 8, "R5 beats seen", nbeats, 8);
    chk(nsupp >= 1, "R6 suppressed candidates", nsupp, 1);
    chk(ntrain_cand >= 1, "R4 training candidates", ntrain_cand, 1);
    chk(nsat >= 1, "R3 saturated squares", nsat, 1);
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule